// File: doc/BRIEF.md
# Hierarchical Adaptive Route Selector

This block picks the output port for a packet when its head flit arrives at a 16-port router. The destination identifier is laid out by packaging level, with a frame field, a board field and a node field. The frame field decides which of two small lookup tables is read. A destination in another frame reads the upper table, which is indexed by the destination frame. A destination in the local frame reads the lower table, which is indexed by the board and node fields taken together. Each table entry is a mask that marks the output ports the packet may use.

A selection stage then chooses one port from that mask. It skips every port that has its fault flag set. Among the ports that remain, it takes the one with the most downstream credits. The result is registered and appears one cycle after the head strobe. If no permitted port is usable, a route-error flag is raised in place of the valid strobe. A simple write port loads the tables. Table storage stays small because the lower table only covers destinations inside the local frame.

Top module: `hier_route_sel`

## Requirements
- R1: While reset is asserted, and after it is released with no head, `rt_vld` and `rt_err` are 0 and `rt_port` is 0. All table entries are cleared to an empty mask.
- R2: Each cycle that `hd_vld` is high produces exactly one of `rt_vld` or `rt_err` on the next cycle. When there is no head on the previous cycle, both are low.
- R3: The destination is `hd_dst = {frame, board, node}`, with the frame field in the most significant bits. When its frame field differs from `local_frame`, the candidate mask is upper-table entry number `frame`.
- R4: When the frame field equals `local_frame`, the candidate mask is lower-table entry number `{board, node}`, and the upper table is not consulted.
- R5: Port i is usable when mask bit i is 1 and `port_fault[i]` is 0. The chosen port is the usable port with the largest credit count. Port i's credit count is `port_cred[i*CRED_W +: CRED_W]`.
- R6: When usable ports tie on the largest credit count, the port with the lowest index is chosen.
- R7: A port whose fault flag was set in the head cycle is never reported with `rt_vld`.
- R8: When no port is usable, including when the mask is empty, `rt_err` is 1 and `rt_vld` is 0 on the next cycle.
- R9: A table write happens when `tbl_we` is 1. `tbl_sel` set to 1 selects the upper table and 0 selects the lower table; `tbl_addr` gives the entry and `tbl_mask` the new mask. A head in the same cycle as the write still sees the old entry, and later heads see the new one.
- R10: `rt_port` keeps its value on cycles that follow a cycle without a head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_frame | input | FRAME_W | Frame field of this router |
| hd_vld | input | 1 | Head flit present this cycle |
| hd_dst | input | FRAME_W+BOARD_W+NODE_W | Destination ID {frame, board, node} |
| port_cred | input | NPORT*CRED_W | Downstream credit count per port |
| port_fault | input | NPORT | Fault flag per port |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 1 = upper table, 0 = lower table |
| tbl_addr | input | TA_W | Table entry index |
| tbl_mask | input | NPORT | Permitted-port mask to store |
| rt_vld | output | 1 | Chosen port valid |
| rt_port | output | PORT_W | Chosen output port |
| rt_err | output | 1 | No usable port for the head |

## Verification
The hardest case to reach is a table write that lands in the same cycle as a head reading that same entry. The ordering rule is only visible in that one cycle. The bench drives the write strobe and the head strobe together on one edge. It sets the credits so that the old mask and the new mask lead to different ports. A second head then confirms that the new mask has taken effect. Ties and faults are reached by setting equal credits on two permitted ports and then flagging the better one as faulty.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  localparam int unsigned HRS_NPORT   = 16;
  localparam int unsigned HRS_FRAME_W = 3;
  localparam int unsigned HRS_BOARD_W = 2;
  localparam int unsigned HRS_NODE_W  = 4;
  localparam int unsigned HRS_CRED_W  = 4;

  function automatic int unsigned hrs_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hrs_mask_table.sv
module hrs_mask_table #(
  parameter int unsigned AW = 3,
  parameter int unsigned W  = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (hit) begin
        ent_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = ent_q[rd_addr];
endmodule

// File: rtl/hrs_utility.sv
module hrs_utility #(
  parameter int unsigned NPORT  = 16,
  parameter int unsigned CRED_W = 4,
  localparam int unsigned PORT_W = $clog2(NPORT)
) (
  input  logic [NPORT-1:0]        cand,
  input  logic [NPORT-1:0]        fault,
  input  logic [NPORT*CRED_W-1:0] cred,
  output logic                    any_ok,
  output logic [PORT_W-1:0]       pick
);
  logic [NPORT-1:0]  usable;
  logic [CRED_W-1:0] cred_a [NPORT];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign usable[g] = cand[g] & ~fault[g];
    assign cred_a[g] = cred[g*CRED_W +: CRED_W];
  end

  logic [CRED_W-1:0] best;

  always_comb begin
    any_ok = 1'b0;
    best   = '0;
    pick   = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (usable[i] && (!any_ok || (cred_a[i] > best))) begin
        any_ok = 1'b1;
        best   = cred_a[i];
        pick   = PORT_W'(i);
      end
    end
  end
endmodule

// File: rtl/hier_route_sel.sv
module hier_route_sel
  import hrs_pkg::*;
#(
  parameter int unsigned NPORT   = HRS_NPORT,
  parameter int unsigned FRAME_W = HRS_FRAME_W,
  parameter int unsigned BOARD_W = HRS_BOARD_W,
  parameter int unsigned NODE_W  = HRS_NODE_W,
  parameter int unsigned CRED_W  = HRS_CRED_W,
  localparam int unsigned PORT_W = $clog2(NPORT),
  localparam int unsigned ID_W   = FRAME_W + BOARD_W + NODE_W,
  localparam int unsigned LO_AW  = BOARD_W + NODE_W,
  localparam int unsigned TA_W   = hrs_max(FRAME_W, LO_AW)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FRAME_W-1:0]      local_frame,
  input  logic                    hd_vld,
  input  logic [ID_W-1:0]         hd_dst,
  input  logic [NPORT*CRED_W-1:0] port_cred,
  input  logic [NPORT-1:0]        port_fault,
  input  logic                    tbl_we,
  input  logic                    tbl_sel,
  input  logic [TA_W-1:0]         tbl_addr,
  input  logic [NPORT-1:0]        tbl_mask,
  output logic                    rt_vld,
  output logic [PORT_W-1:0]       rt_port,
  output logic                    rt_err
);
  logic [FRAME_W-1:0] dst_frame;
  logic [LO_AW-1:0]   dst_local;
  logic               go_up;
  logic [NPORT-1:0]   up_mask, lo_mask, cand;
  logic               any_ok;
  logic [PORT_W-1:0]  pick;

  assign dst_frame = hd_dst[ID_W-1 -: FRAME_W];
  assign dst_local = hd_dst[LO_AW-1:0];
  assign go_up     = (dst_frame != local_frame);

  hrs_mask_table #(.AW(FRAME_W), .W(NPORT)) u_upper (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we & tbl_sel),
    .wr_addr (tbl_addr[FRAME_W-1:0]),
    .wr_data (tbl_mask),
    .rd_addr (dst_frame),
    .rd_data (up_mask)
  );

  hrs_mask_table #(.AW(LO_AW), .W(NPORT)) u_lower (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we & ~tbl_sel),
    .wr_addr (tbl_addr[LO_AW-1:0]),
    .wr_data (tbl_mask),
    .rd_addr (dst_local),
    .rd_data (lo_mask)
  );

  assign cand = go_up ? up_mask : lo_mask;

  hrs_utility #(.NPORT(NPORT), .CRED_W(CRED_W)) u_util (
    .cand   (cand),
    .fault  (port_fault),
    .cred   (port_cred),
    .any_ok (any_ok),
    .pick   (pick)
  );

  logic              vld_d, err_d, port_en;
  logic [PORT_W-1:0] port_d;

  always_comb begin
    vld_d   = hd_vld & any_ok;
    err_d   = hd_vld & ~any_ok;
    port_en = hd_vld;
    port_d  = any_ok ? pick : rt_port;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_vld <= 1'b0;
      rt_err <= 1'b0;
    end else begin
      rt_vld <= vld_d;
      rt_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_port <= '0;
    end else if (port_en) begin
      rt_port <= port_d;
    end
  end
endmodule

// File: rtl/hier_route_sel_chk.sv
module hier_route_sel_chk #(
  parameter int unsigned NPORT  = 16,
  parameter int unsigned PORT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hd_vld,
  input logic [NPORT-1:0]  port_fault,
  input logic              rt_vld,
  input logic              rt_err,
  input logic [PORT_W-1:0] rt_port
);
  logic [NPORT-1:0] fault_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      fault_q <= port_fault;
      seen_q  <= 1'b1;
    end
  end

  p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hd_vld |=> (rt_vld ^ rt_err));

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hd_vld |=> (!rt_vld && !rt_err));

  p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rt_vld && rt_err));

  p_no_faulty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_vld && seen_q) |-> !fault_q[rt_port]);

  p_port_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd_vld && seen_q) |=> $stable(rt_port));
endmodule

bind hier_route_sel hier_route_sel_chk #(.NPORT(NPORT), .PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hd_vld     (hd_vld),
  .port_fault (port_fault),
  .rt_vld     (rt_vld),
  .rt_err     (rt_err),
  .rt_port    (rt_port)
);

// File: tb/test_hier_route_sel.sv
module test_hier_route_sel;
  localparam int NPORT = 16, CRED_W = 4, PORT_W = 4, ID_W = 9, TA_W = 6;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [2:0]              local_frame;
  logic                    hd_vld;
  logic [ID_W-1:0]         hd_dst;
  logic [NPORT*CRED_W-1:0] port_cred;
  logic [NPORT-1:0]        port_fault;
  logic                    tbl_we, tbl_sel;
  logic [TA_W-1:0]         tbl_addr;
  logic [NPORT-1:0]        tbl_mask;
  logic                    rt_vld, rt_err;
  logic [PORT_W-1:0]       rt_port;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  hier_route_sel i_hier_route_sel (
    .clk(clk), .rst_n(rst_n), .local_frame(local_frame), .hd_vld(hd_vld),
    .hd_dst(hd_dst), .port_cred(port_cred), .port_fault(port_fault),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_mask(tbl_mask),
    .rt_vld(rt_vld), .rt_port(rt_port), .rt_err(rt_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cred(input int p, input int v);
    port_cred[p*CRED_W +: CRED_W] = CRED_W'(v);
  endtask

  task automatic prog(input bit sel, input int addr, input logic [NPORT-1:0] m);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = TA_W'(addr); tbl_mask = m;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // drive one head at a negedge, check result at the following negedge
  task automatic head(input int fr, input int bd, input int nd,
                      input string req, input int exp_vld, input int exp_err, input int exp_port);
    @(negedge clk);
    hd_vld = 1'b1; hd_dst = {3'(fr), 2'(bd), 4'(nd)};
    @(negedge clk);
    hd_vld = 1'b0;
    check(req, rt_vld, exp_vld);
    check(req, rt_err, exp_err);
    if (exp_vld != 0) check(req, rt_port, exp_port);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hd_vld = 1'b0; hd_dst = '0; tbl_we = 1'b0; tbl_sel = 1'b0;
    tbl_addr = '0; tbl_mask = '0; port_cred = '0; port_fault = '0; local_frame = 3'd2;
    repeat (3) @(negedge clk);
    check("R1 vld", rt_vld, 0); check("R1 err", rt_err, 0); check("R1 port", rt_port, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vld after release", rt_vld, 0);
    head(2, 1, 3, "R1 empty table gives err", 0, 1, 0);
  endtask

  task automatic t_upper();
    for (int i = 0; i < NPORT; i++) set_cred(i, 1);
    set_cred(6, 9);
    prog(1'b1, 5, 16'h00F0);
    head(5, 0, 0, "R3 upper lookup", 1, 0, 6);
    head(5, 3, 15, "R3 upper ignores board/node", 1, 0, 6);
  endtask

  task automatic t_lower();
    prog(1'b1, 2, 16'h8000);
    set_cred(1, 7);
    prog(1'b0, 19, 16'h0003);
    head(2, 1, 3, "R4 lower lookup", 1, 0, 1);
    head(2, 1, 4, "R8 unprogrammed lower entry", 0, 1, 0);
  endtask

  task automatic t_tie_fault();
    prog(1'b0, 19, 16'h0C00);
    set_cred(10, 5); set_cred(11, 5);
    head(2, 1, 3, "R6 tie lowest index", 1, 0, 10);
    set_cred(11, 6);
    head(2, 1, 3, "R5 higher credit wins", 1, 0, 11);
    set_cred(10, 9); set_cred(11, 1);
    port_fault = 16'h0400;
    head(2, 1, 3, "R7 faulty port skipped", 1, 0, 11);
    port_fault = 16'h0C00;
    head(2, 1, 3, "R8 all candidates faulty", 0, 1, 0);
    port_fault = '0;
  endtask

  task automatic t_write_order();
    // upper[5] = 0x00F0 picks 6; new mask 0x0001 picks 0
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 1'b1; tbl_addr = 6'd5; tbl_mask = 16'h0001;
    hd_vld = 1'b1; hd_dst = {3'd5, 2'd0, 4'd0};
    @(negedge clk);
    tbl_we = 1'b0; hd_vld = 1'b0;
    check("R9 same-cycle write unseen vld", rt_vld, 1);
    check("R9 same-cycle write unseen port", rt_port, 6);
    head(5, 0, 0, "R9 write seen by next head", 1, 0, 0);
  endtask

  task automatic t_idle();
    head(5, 0, 0, "R2 head result", 1, 0, 0);
    set_cred(0, 0);
    prog(1'b1, 5, 16'h0010);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 no head no vld", rt_vld, 0);
      check("R2 no head no err", rt_err, 0);
      check("R10 port held", rt_port, 0);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_upper();
        t_lower();
        t_tie_fault();
        t_write_order();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule